// File: doc/BRIEF.md
# Byte-Lane Read Parity Checker

This block sits beside a 64-bit data port built from eight byte lanes. When a read completes, it tests each lane of the returned data against that lane's parity bit. Only lanes whose active-low byte enable is asserted are judged. The result appears in two forms. The first is a registered per-lane error vector. The second is an active-low check flag, which pulses in the clock after the read data was sampled.

A global parity-on input sets whether a detected mismatch drives the check flag. The error vector records mismatches in either case.

For outgoing data the block also forms one parity bit per lane. Each bit is chosen so that the lane's eight data bits plus the parity bit hold an even number of ones.

Top module: `lane_parity_guard`

## Requirements
- R1: Lane i covers data bits [8i+7:8i] and is paired with parity bit i and byte enable bit i, for i from 0 to 7.
- R2: A lane mismatches when its eight data bits together with its parity bit hold an odd number of ones.
- R3: A lane whose byte enable is high (deasserted) never sets its error bit, whatever its data and parity.
- R4: Any pattern of asserted byte enables is judged lane by lane, including non-contiguous patterns.
- R5: A qualified read is a rising clock edge with `readValid` high. At that edge `laneErr` loads the masked mismatch of every lane, and the new value is visible after the edge.
- R6: After a qualified read with `parityOn` high, `checkN` is low for exactly the following clock cycle if any enabled lane mismatched. Otherwise it stays high.
- R7: With `parityOn` low during a read, `checkN` stays high while `laneErr` still records the mismatches.
- R8: On edges without `readValid`, `laneErr` keeps its value and `checkN` is high.
- R9: For every lane, `writeParity[i]` makes `writeData` lane i plus that bit hold an even number of ones. This output is combinational.
- R10: While `rstN` is low, `checkN` is high and `laneErr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| readData | input | 64 | Returned read data, eight byte lanes |
| readParity | input | 8 | One parity bit per lane |
| laneEnN | input | 8 | Active-low byte enables |
| parityOn | input | 1 | Lets a mismatch drive the check flag |
| readValid | input | 1 | Qualifies the current edge as a read sample |
| writeData | input | 64 | Outgoing data |
| writeParity | output | 8 | Even parity per outgoing lane |
| checkN | output | 1 | Active-low parity-check flag, one cycle after the read |
| laneErr | output | 8 | Registered per-lane mismatch vector |

## Verification
A mis-wired lane slice or a flipped parity sense shows up in `laneErr` one edge after the first read that stresses that lane. For this reason the stimulus corrupts single lanes, lanes at both ends of the bus, and a scattered enable pattern. A mask applied the wrong way round sets error bits on disabled lanes in that same cycle.

A stuck flag register either holds `checkN` low past its single cycle or fails to drop it. The bench checks this on the cycle right after each read and again on the idle cycles that follow.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  localparam int LPG_LANES  = 8;
  localparam int LPG_LANE_W = 8;

  typedef struct packed {
    logic capture;
    logic judge;
  } lpg_strobe_t;
endpackage

// File: rtl/lpg_datapath.sv
module lpg_datapath
  import lpg_pkg::*;
#(
  parameter int LANES  = LPG_LANES,
  parameter int LANE_W = LPG_LANE_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  lpg_strobe_t       strobe,
  input  logic [DATA_W-1:0] readData,
  input  logic [LANES-1:0]  readParity,
  input  logic [LANES-1:0]  laneEnN,
  input  logic [DATA_W-1:0] writeData,
  output logic [LANES-1:0]  writeParity,
  output logic [LANES-1:0]  laneErr,
  output logic              anyLiveErr
);
  logic [LANES-1:0] laneOdd;
  logic [LANES-1:0] laneLive;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneOdd[g]     = ^{readData[g*LANE_W +: LANE_W], readParity[g]};
    assign writeParity[g] = ^writeData[g*LANE_W +: LANE_W];
  end

  assign laneLive   = laneOdd & ~laneEnN;
  assign anyLiveErr = |laneLive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneErr <= '0;
    end else if (strobe.capture) begin
      laneErr <= laneLive;
    end
  end
endmodule

// File: rtl/lpg_ctrl.sv
module lpg_ctrl
  import lpg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        readValid,
  input  logic        parityOn,
  input  logic        anyLiveErr,
  output lpg_strobe_t strobe,
  output logic        checkN
);
  always_comb begin
    strobe.capture = readValid;
    strobe.judge   = readValid & parityOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      checkN <= 1'b1;
    end else if (strobe.judge) begin
      checkN <= ~anyLiveErr;
    end else begin
      checkN <= 1'b1;
    end
  end
endmodule

// File: rtl/lane_parity_guard.sv
module lane_parity_guard
  import lpg_pkg::*;
#(
  parameter int LANES  = LPG_LANES,
  parameter int LANE_W = LPG_LANE_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] readData,
  input  logic [LANES-1:0]  readParity,
  input  logic [LANES-1:0]  laneEnN,
  input  logic              parityOn,
  input  logic              readValid,
  input  logic [DATA_W-1:0] writeData,
  output logic [LANES-1:0]  writeParity,
  output logic              checkN,
  output logic [LANES-1:0]  laneErr
);
  lpg_strobe_t strobe;
  logic        anyLiveErr;

  lpg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .readValid  (readValid),
    .parityOn   (parityOn),
    .anyLiveErr (anyLiveErr),
    .strobe     (strobe),
    .checkN     (checkN)
  );

  lpg_datapath #(.LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .readData    (readData),
    .readParity  (readParity),
    .laneEnN     (laneEnN),
    .writeData   (writeData),
    .writeParity (writeParity),
    .laneErr     (laneErr),
    .anyLiveErr  (anyLiveErr)
  );
endmodule

// File: rtl/lpg_checker.sv
module lpg_checker #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [LANES-1:0]  laneEnN,
  input logic              parityOn,
  input logic              readValid,
  input logic [DATA_W-1:0] writeData,
  input logic [LANES-1:0]  writeParity,
  input logic              checkN,
  input logic [LANES-1:0]  laneErr
);
  // R6: a low flag must follow an enabled read
  assert_flag_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    !checkN |-> $past(readValid && parityOn));

  // R6: flag agrees with the captured vector
  assert_flag_match_R6: assert property (@(posedge clk) disable iff (!rstN)
    (readValid && parityOn) |=> (checkN == (laneErr == '0)));

  // R7: parity off keeps the flag high
  assert_flag_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !parityOn |=> checkN);

  // R8: vector holds without a read
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !readValid |=> $stable(laneErr));

  // R3: only enabled lanes may carry an error
  assert_masked_R3: assert property (@(posedge clk) disable iff (!rstN)
    readValid |=> ((laneErr & ~$past(laneEnN)) == laneErr));

  // R9: generated parity is even per lane
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (!$isunknown({writeData[i*LANE_W +: LANE_W], writeParity[i]})) begin
        assert_wr_even_R9: assert (^{writeData[i*LANE_W +: LANE_W], writeParity[i]} == 1'b0);
      end
    end
  end
endmodule

bind lane_parity_guard lpg_checker #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .laneEnN     (laneEnN),
  .parityOn    (parityOn),
  .readValid   (readValid),
  .writeData   (writeData),
  .writeParity (writeParity),
  .checkN      (checkN),
  .laneErr     (laneErr)
);

// File: tb/sim_lane_parity_guard.sv
module sim_lane_parity_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] readData = '0;
  logic [7:0]  readParity = '0;
  logic [7:0]  laneEnN = 8'hFF;
  logic        parityOn = 1'b0;
  logic        readValid = 1'b0;
  logic [63:0] writeData = '0;
  logic [7:0]  writeParity;
  logic        checkN;
  logic [7:0]  laneErr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct packed {
    logic [7:0] err;
    logic       chk;
  } exp_t;
  exp_t  expQ[$];
  string tagQ[$];

  lane_parity_guard u0 (
    .clk(clk), .rstN(rstN), .readData(readData), .readParity(readParity),
    .laneEnN(laneEnN), .parityOn(parityOn), .readValid(readValid),
    .writeData(writeData), .writeParity(writeParity),
    .checkN(checkN), .laneErr(laneErr)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] evenPar(logic [63:0] d);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) begin
      p[i] = 1'b0;
      for (int b = 0; b < 8; b++) p[i] = p[i] ^ d[i*8 + b];
    end
    return p;
  endfunction

  function automatic logic [7:0] expectErr(logic [63:0] d, logic [7:0] p, logic [7:0] enN);
    logic [7:0] e;
    for (int i = 0; i < 8; i++) begin
      int ones = 0;
      for (int b = 0; b < 8; b++) ones += int'(d[i*8 + b]);
      ones += int'(p[i]);
      e[i] = (ones % 2 == 1) && !enN[i];
    end
    return e;
  endfunction

  task automatic checkEq(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one read cycle, expected result pushed to the scoreboard
  task automatic doRead(logic [63:0] d, logic [7:0] p, logic [7:0] enN, logic on, string tag);
    exp_t e;
    @(negedge clk);
    readData = d; readParity = p; laneEnN = enN; parityOn = on; readValid = 1'b1;
    e.err = expectErr(d, p, enN);
    e.chk = !(on && (e.err != 8'h00));
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    readValid = 1'b0;
  endtask

  // monitor
  logic sawRead = 1'b0;
  always @(posedge clk) sawRead <= readValid && rstN;

  always @(negedge clk) begin
    if (sawRead && expQ.size() > 0) begin
      exp_t  e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checkEq({t, " laneErr"}, {56'h0, laneErr}, {56'h0, e.err});
      checkEq({t, " checkN"}, {63'h0, checkN}, {63'h0, e.chk});
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [7:0]  keep;
    repeat (3) @(negedge clk);
    checkEq("R10 reset checkN", {63'h0, checkN}, 64'h1);
    checkEq("R10 reset laneErr", {56'h0, laneErr}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    d = 64'h0123_4567_89AB_CDEF;
    doRead(d, evenPar(d), 8'h00, 1'b1, "R1 R2 clean read");
    doRead(d, evenPar(d) ^ 8'h08, 8'h00, 1'b1, "R2 R6 lane3 bad");
    d = 64'hFF00_A5C3_0F80_7E11;
    doRead(d, evenPar(d) ^ 8'h81, 8'h80, 1'b1, "R1 R3 end lanes, lane7 masked");
    doRead(d, ~evenPar(d), 8'b0101_1010, 1'b1, "R4 scattered enables");
    doRead(d, ~evenPar(d), 8'hFF, 1'b1, "R3 all lanes masked");
    doRead(64'hFFFF_FFFF_FFFF_FFFF, 8'h00, 8'h00, 1'b1, "R2 all ones even");
    doRead(64'h0000_0000_0000_0001, 8'h00, 8'h00, 1'b1, "R1 lane0 single bit");
    doRead(d, evenPar(d) ^ 8'h24, 8'h00, 1'b0, "R7 parity off");
    doRead(d, evenPar(d) ^ 8'h10, 8'h00, 1'b1, "R5 reload");

    // R8: idle edges keep the vector, flag high
    @(negedge clk);
    keep = expectErr(d, evenPar(d) ^ 8'h10, 8'h00);
    readData = ~d; readParity = 8'h00; laneEnN = 8'h00; parityOn = 1'b1;
    repeat (2) @(negedge clk);
    checkEq("R8 idle laneErr", {56'h0, laneErr}, {56'h0, keep});
    checkEq("R8 idle checkN", {63'h0, checkN}, 64'h1);

    // R9: write parity
    for (int k = 0; k < 4; k++) begin
      writeData = {32'hDEAD_BEEF, 32'h1357_9BDF} ^ (64'h0F0F_3C3C_5A5A_9696 << (k * 7));
      #1;
      checkEq("R9 write parity", {56'h0, writeParity}, {56'h0, evenPar(writeData)});
    end

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule